// File: doc/BRIEF.md
# SMBus Configuration Register Target

This block is an SMBus/I2C target that gives a host controller access to a small bank of 8-bit configuration registers. It watches SCL and SDA, which are already synchronised to the fast system clock, and sees bus edges, start and stop conditions by oversampling them. It answers only at a fixed 7-bit device address, 0x69. On the wire that is 0xD2 for a write and 0xD3 for a read. It pulls SDA low through a single open-drain enable output.

A command byte follows the address. When its top bit is set, the transfer is a single-byte access, and the low seven bits name the register. When the top bit is clear, the transfer is a block access that starts at register 0 and moves upward one register per byte. A block write carries a byte-count byte, which the target accepts and does not use. A block read first returns the number of implemented registers and then returns the register contents. All bytes travel MSB first.

Some bit positions are read-only. The parameter RO_MASK selects them. A read of those positions returns the live value of the external input ext_ro_i, and a write leaves them unchanged. The stored register values drive cfg_o toward the rest of the chip. The block has no streaming port. SMBus without clock stretching gives no back-pressure, so every byte the target acknowledges is committed at once. The interface depends only on the system clock and SCL/SDA. It therefore keeps working while the clocks it configures are stopped.

Top module: `smbus_cfg_target`

## Requirements
- R1: The address byte 0xD2 (write) or 0xD3 (read) gets an ACK. Any other address byte gets a NACK. The target then ignores the bus until the next start condition: it drives no ACK for any later byte and changes no register.
- R2: In a write with command bit 7 = 1, bits 6:0 give the register offset, and the data byte that follows is written to that register.
- R3: In a byte read, the target returns the register selected by the preceding command, MSB first, after a repeated start with address 0xD3.
- R4: In a write with command bit 7 = 0, the next byte is a byte count. The target ACKs it and discards it. The data bytes after it go to offsets 0, 1, 2 and upward.
- R5: In a block read (command 0x00, repeated start, 0xD3), the first byte returned is NREG (default 15). The contents of offsets 0, 1, 2 and upward follow.
- R6: The master may end any transfer after any complete byte. A partial block write changes only the registers whose data bytes were sent, and a block read ended early leaves the target ready for the next start.
- R7: A write to any offset at or above NREG gets an ACK and is discarded. A read of such an offset, including reads that run past the end of a block read, returns 0x00.
- R8: Writes leave read-only positions unchanged. By default these are bits 4:0 of offset 0 and all of offset 7. A read of a read-only position returns the matching bit of ext_ro_i. In cfg_o, read-only positions keep their reset value.
- R9: After reset, cfg_o equals the default values from offset 0 to offset 14: 40 7F 00 FF 47 D7 03 00 60 1C 0F 00 00 00 40 (hex). SDA is released.
- R10: The target changes its SDA drive only while SCL is low. It drives SDA only in its own ACK slots and in the data bits it sends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level (wired bus value) |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| ext_ro_i | input | NREG*8 | Live values for read-only bit positions, offset 0 in the low byte |
| cfg_o | output | NREG*8 | Stored register values, offset 0 in the low byte |

## Verification
The bench builds the block with the default parameters: 15 registers, device address 0x69, read-only bits in offsets 0 and 7, and the default reset values. With these settings, single-byte offsets 20 and 127 fall beyond the register bank. A 17-byte block write runs two bytes past the last register, and a block read can ask for one byte more than the count it reports. The bench drives ext_ro_i with values that differ from the stored bits, so every read shows whether the read-only merge takes the live input.

// File: rtl/smbt_pkg.sv
package smbt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK
  } smbt_state_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_CNT,
    PH_DATA
  } smbt_phase_e;
endpackage

// File: rtl/smbt_bus_detect.sv
module smbt_bus_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o    = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_o     = scl_q & scl_i & ~sda_q & sda_i;
  assign scl_rise_o = ~scl_q & scl_i;
  assign scl_fall_o = scl_q & ~scl_i;
endmodule

// File: rtl/smbt_regbank.sv
module smbt_regbank #(
  parameter int NREG = 15,
  parameter logic [NREG*8-1:0] RST_VAL = '0,
  parameter logic [NREG*8-1:0] RO_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [7:0]        rd_addr_i,
  output logic [7:0]        rd_data_o,
  input  logic [NREG*8-1:0] ext_ro_i,
  output logic [NREG*8-1:0] cfg_o
);
  logic [7:0] merged [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [7:0] RO = RO_MASK[g*8 +: 8];
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL[g*8 +: 8];
      else if (wr_en_i && wr_addr_i == 8'(g)) q <= (wr_data_i & ~RO) | (q & RO);
    end
    assign cfg_o[g*8 +: 8] = q;
    assign merged[g] = (q & ~RO) | (ext_ro_i[g*8 +: 8] & RO);
  end

  always_comb begin
    rd_data_o = 8'h00;
    for (int i = 0; i < NREG; i++)
      if (rd_addr_i == 8'(i)) rd_data_o = merged[i];
  end

  // R8
  ro_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(cfg_o & RO_MASK));
  // R7
  oob_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i >= 8'(NREG)) |=> $stable(cfg_o));
endmodule

// File: rtl/smbt_engine.sv
module smbt_engine
  import smbt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int NREG = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_i,
  input  logic       scl_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  output logic       sda_oe_o,
  output logic       wr_en_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o,
  output logic [7:0] rd_addr_o,
  input  logic [7:0] rd_data_i
);
  localparam logic [7:0] CNT_BYTE = 8'(NREG);

  smbt_state_e st;
  smbt_phase_e ph;
  logic [3:0]  bitcnt;
  logic [7:0]  sh;
  logic [7:0]  ptr;
  logic        rd_go, blk, cnt_pend, mack;
  logic [7:0]  tx_next;

  assign rd_addr_o = ptr;
  assign tx_next   = cnt_pend ? CNT_BYTE : rd_data_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; ph <= PH_ADDR; bitcnt <= '0; sh <= '0; ptr <= '0;
      rd_go <= 1'b0; blk <= 1'b0; cnt_pend <= 1'b0; mack <= 1'b0;
      sda_oe_o <= 1'b0; wr_en_o <= 1'b0; wr_addr_o <= '0; wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (stop_i) begin
        st <= ST_IDLE; sda_oe_o <= 1'b0; blk <= 1'b0; ptr <= '0;
        cnt_pend <= 1'b0; rd_go <= 1'b0;
      end else if (start_i) begin
        st <= ST_RX; ph <= PH_ADDR; bitcnt <= '0; sda_oe_o <= 1'b0; rd_go <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise_i && bitcnt != 4'd8) begin
              sh <= {sh[6:0], sda_i};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall_i && bitcnt == 4'd8) begin
              st <= ST_RXACK;
              sda_oe_o <= 1'b1;
              case (ph)
                PH_ADDR: begin
                  if (sh[7:1] == DEV_ADDR) begin
                    if (sh[0]) begin rd_go <= 1'b1; cnt_pend <= blk; end
                    else ph <= PH_CMD;
                  end else begin
                    st <= ST_IDLE; sda_oe_o <= 1'b0;
                  end
                end
                PH_CMD: begin
                  blk <= ~sh[7];
                  ptr <= sh[7] ? {1'b0, sh[6:0]} : 8'h00;
                  ph  <= sh[7] ? PH_DATA : PH_CNT;
                end
                PH_CNT: ph <= PH_DATA;
                default: begin
                  wr_en_o <= 1'b1; wr_addr_o <= ptr; wr_data_o <= sh;
                  if (ptr != 8'hFF) ptr <= ptr + 8'd1;
                end
              endcase
            end
          end
          ST_RXACK: if (scl_fall_i) begin
            if (rd_go) begin
              st <= ST_TX; sda_oe_o <= ~tx_next[7];
              sh <= {tx_next[6:0], 1'b0}; bitcnt <= 4'd1;
              if (cnt_pend) cnt_pend <= 1'b0;
              else if (ptr != 8'hFF) ptr <= ptr + 8'd1;
            end else begin
              st <= ST_RX; sda_oe_o <= 1'b0; bitcnt <= '0;
            end
          end
          ST_TX: if (scl_fall_i) begin
            if (bitcnt == 4'd8) begin
              sda_oe_o <= 1'b0; st <= ST_TXACK;
            end else begin
              sda_oe_o <= ~sh[7]; sh <= {sh[6:0], 1'b0}; bitcnt <= bitcnt + 4'd1;
            end
          end
          ST_TXACK: begin
            if (scl_rise_i) mack <= ~sda_i;
            else if (scl_fall_i) begin
              if (mack) begin
                st <= ST_TX; sda_oe_o <= ~tx_next[7];
                sh <= {tx_next[6:0], 1'b0}; bitcnt <= 4'd1;
                if (cnt_pend) cnt_pend <= 1'b0;
                else if (ptr != 8'hFF) ptr <= ptr + 8'd1;
              end else st <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10
  sda_stable_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe_o));
  // R1
  idle_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe_o);
  // R3
  tx_only_after_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TX) |-> rd_go);
endmodule

// File: rtl/smbus_cfg_target.sv
module smbus_cfg_target #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int NREG = 15,
  parameter logic [NREG*8-1:0] RST_VAL = {8'h40, 8'h00, 8'h00, 8'h00, 8'h0F, 8'h1C, 8'h60,
                                          8'h00, 8'h03, 8'hD7, 8'h47, 8'hFF, 8'h00, 8'h7F, 8'h40},
  parameter logic [NREG*8-1:0] RO_MASK = {{7{8'h00}}, 8'hFF, {6{8'h00}}, 8'h1F}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [NREG*8-1:0] ext_ro_i,
  output logic [NREG*8-1:0] cfg_o
);
  logic start, stop, scl_rise, scl_fall;
  logic wr_en;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;

  smbt_bus_detect u_detect (
    .clk, .rst_n, .scl_i, .sda_i,
    .start_o(start), .stop_o(stop), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall)
  );

  smbt_engine #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_engine (
    .clk, .rst_n, .sda_i, .scl_i,
    .start_i(start), .stop_i(stop), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .sda_oe_o,
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  smbt_regbank #(.NREG(NREG), .RST_VAL(RST_VAL), .RO_MASK(RO_MASK)) u_bank (
    .clk, .rst_n,
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .ext_ro_i, .cfg_o
  );
endmodule

// File: tb/smbus_cfg_target_bench.sv
module smbus_cfg_target_bench;
  localparam int NR = 15;
  localparam logic [NR*8-1:0] DEF = {8'h40, 8'h00, 8'h00, 8'h00, 8'h0F, 8'h1C, 8'h60,
                                     8'h00, 8'h03, 8'hD7, 8'h47, 8'hFF, 8'h00, 8'h7F, 8'h40};
  localparam logic [NR*8-1:0] ROM = {{7{8'h00}}, 8'hFF, {6{8'h00}}, 8'h1F};
  localparam logic [NR*8-1:0] EXT = {{7{8'hAA}}, 8'h41, {6{8'hAA}}, 8'h15};
  // {offset, write data, expected read}
  localparam logic [23:0] VEC [8] = '{
    24'h01A5A5, 24'h033C3C, 24'h00FFF5, 24'h070041,
    24'h0E8181, 24'h147700, 24'h090000, 24'h7F1200
  };

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, sda_bus;
  logic [NR*8-1:0] cfg;
  int nchk = 0, nerr = 0;
  logic [7:0] mdl [NR];

  always #5 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  smbus_cfg_target u_smbus_cfg_target (
    .clk, .rst_n, .scl_i(m_scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .ext_ro_i(EXT), .cfg_o(cfg)
  );

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bstart();
    m_sda = 1'b1; w(2); m_scl = 1'b1; w(4); m_sda = 1'b0; w(4); m_scl = 1'b0; w(2);
  endtask
  task automatic bstop();
    m_scl = 1'b0; w(2); m_sda = 1'b0; w(2); m_scl = 1'b1; w(4); m_sda = 1'b1; w(4);
  endtask
  task automatic txb(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_scl = 1'b0; w(2); m_sda = b[i]; w(2); m_scl = 1'b1; w(4);
    end
    m_scl = 1'b0; w(2); m_sda = 1'b1; w(2); m_scl = 1'b1; w(2);
    ack = ~sda_bus; w(2); m_scl = 1'b0;
  endtask
  task automatic rxb(input logic nack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      m_scl = 1'b0; w(4); m_scl = 1'b1; w(2); b[i] = sda_bus; w(2);
    end
    m_scl = 1'b0; w(2); m_sda = nack; w(2); m_scl = 1'b1; w(4); m_scl = 1'b0; w(2); m_sda = 1'b1;
  endtask

  function automatic logic [7:0] exp_rd(input int i);
    if (i >= NR) return 8'h00;
    return (mdl[i] & ~ROM[i*8 +: 8]) | (EXT[i*8 +: 8] & ROM[i*8 +: 8]);
  endfunction
  function automatic logic [NR*8-1:0] mdl_vec();
    logic [NR*8-1:0] v;
    for (int i = 0; i < NR; i++) v[i*8 +: 8] = mdl[i];
    return v;
  endfunction
  task automatic mdl_wr(input int i, input logic [7:0] d);
    if (i < NR) mdl[i] = (d & ~ROM[i*8 +: 8]) | (mdl[i] & ROM[i*8 +: 8]);
  endtask

  task automatic byte_wr(input logic [6:0] off, input logic [7:0] d, output logic allack);
    logic a0, a1, a2;
    bstart(); txb(8'hD2, a0); txb({1'b1, off}, a1); txb(d, a2); bstop();
    allack = a0 & a1 & a2;
  endtask
  task automatic byte_rd(input logic [6:0] off, output logic [7:0] d, output logic allack);
    logic a0, a1, a2;
    bstart(); txb(8'hD2, a0); txb({1'b1, off}, a1);
    bstart(); txb(8'hD3, a2); rxb(1'b1, d); bstop();
    allack = a0 & a1 & a2;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin : main
    logic ok, a;
    logic [7:0] d, cnt;
    for (int i = 0; i < NR; i++) mdl[i] = DEF[i*8 +: 8];
    w(4); rst_n = 1'b1; w(4);

    // R9 reset state
    chk(cfg == DEF, "R9 cfg after reset", cfg, DEF);
    chk(sda_oe == 1'b0, "R9 sda released", sda_oe, 0);
    byte_rd(7'd5, d, ok);
    chk(ok && d == 8'hD7, "R3 byte read of default", d, 8'hD7);

    // R2 R3 R7 R8 vector table
    for (int v = 0; v < 8; v++) begin
      byte_wr(VEC[v][22:16], VEC[v][15:8], ok);
      chk(ok, "R1 R2 write acked", ok, 1);
      mdl_wr(int'(VEC[v][23:16]), VEC[v][15:8]);
      byte_rd(VEC[v][22:16], d, ok);
      chk(ok && d == VEC[v][7:0], "R2 R3 R7 R8 readback", d, VEC[v][7:0]);
    end
    chk(cfg == mdl_vec(), "R8 cfg after vectors", cfg, mdl_vec());

    // R1 address mismatch
    bstart(); txb(8'hA4, a);
    chk(a == 1'b0, "R1 foreign address nacked", a, 0);
    txb(8'h81, a); chk(a == 1'b0, "R1 ignored command", a, 0);
    txb(8'h55, a); chk(a == 1'b0, "R1 ignored data", a, 0);
    bstop();
    chk(cfg == mdl_vec(), "R1 no register change", cfg, mdl_vec());

    // R4 R6 partial block write
    bstart(); txb(8'hD2, ok); txb(8'h00, a); ok &= a; txb(8'h03, a); ok &= a;
    txb(8'hB1, a); ok &= a; txb(8'h22, a); ok &= a; bstop();
    mdl_wr(0, 8'hB1); mdl_wr(1, 8'h22);
    chk(ok, "R4 block write acked", ok, 1);
    chk(cfg == mdl_vec(), "R4 R6 partial block write", cfg, mdl_vec());

    // R7 block write past the end
    bstart(); txb(8'hD2, ok); txb(8'h00, a); ok &= a; txb(8'h11, a); ok &= a;
    for (int i = 0; i < NR + 2; i++) begin
      txb(8'(8'h80 + i), a); ok &= a;
      mdl_wr(i, 8'(8'h80 + i));
    end
    bstop();
    chk(ok, "R7 overrun bytes acked", ok, 1);
    chk(cfg == mdl_vec(), "R4 R7 full block write", cfg, mdl_vec());

    // R5 block read with one extra byte
    bstart(); txb(8'hD2, ok); txb(8'h00, a); ok &= a;
    bstart(); txb(8'hD3, a); ok &= a;
    rxb(1'b0, cnt);
    chk(ok && cnt == 8'(NR), "R5 block count", cnt, NR);
    for (int i = 0; i < NR; i++) begin
      rxb(1'b0, d);
      chk(d == exp_rd(i), "R5 R8 block read data", d, exp_rd(i));
    end
    rxb(1'b1, d); bstop();
    chk(d == 8'h00, "R7 read past end", d, 0);

    // R6 early end of block read
    bstart(); txb(8'hD2, ok); txb(8'h00, a);
    bstart(); txb(8'hD3, a); rxb(1'b0, cnt); rxb(1'b0, d); rxb(1'b1, d); bstop();
    chk(d == exp_rd(1), "R6 early stop data", d, exp_rd(1));
    byte_rd(7'd3, d, ok);
    chk(ok && d == exp_rd(3), "R6 access after early stop", d, exp_rd(3));

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule